// File: doc/BRIEF.md
# Corrective Pulse Burst Filter

This block sits on the correction path of a digital clock-recovery loop. It takes the phase detector's advance and retard pulses and forwards them to the oscillator control. It forwards them only when they arrive as a sustained run, which is what a real phase or frequency offset produces. An isolated pulse, a short burst of spurious corrections, or a brief dropout of the reference is treated as noise. In those cases the oscillator control sees nothing, and the loop stays in its steady tracking state.

The filter counts consecutive corrections of the same direction. A correction counts as consecutive when it arrives within a window of `GAP_WIN` clock cycles after the previous one. When the run reaches a programmed threshold, the path opens and every following correction passes through, so the loop behaves as an ordinary loop while it re-tunes. Once the corrections stop for a full window, the block emits a single-cycle re-arm pulse, clears its counters, reloads the threshold and closes the path again.

Top module: `cpbf_burst_filter`

## Requirements
- R1: After reset, `adv_o`, `ret_o`, `open_o` and `rearm_o` are all low, and the threshold register holds the value present on `thresh_i` during reset.
- R2: A cycle is a correction only when exactly one of `adv_i` (advance, encoded 1 on that pin) or `ret_i` is high. When both or neither are high, nothing is forwarded and the run count does not change.
- R3: While the path is closed, a correction is withheld unless the run count including it reaches the held threshold. A held threshold of 0 behaves as 1.
- R4: The correction that brings the run to the threshold is forwarded. `open_o` is high from the same output cycle onward, and every later correction is forwarded while the path stays open.
- R5: A correction extends the run only if it arrives no more than `GAP_WIN` cycles after the previous correction. Otherwise the run restarts at 1.
- R6: After `GAP_WIN` consecutive cycles without a correction following a run, `rearm_o` pulses high for exactly one cycle, `open_o` falls in that same cycle, and the run count clears.
- R7: While the path is closed, a correction whose direction differs from the previous one restarts the run at 1. While the path is open, both directions are forwarded.
- R8: The held threshold changes only at reset and at a re-arm. A change on `thresh_i` at any other time has no effect on which pulses are forwarded.
- R9: With `REG_OUT`=1, the outputs are registered. A forwarded correction appears on `adv_o` or `ret_o` exactly one clock cycle after it is presented, and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_i | input | 1 | Advance (speed-up) correction from the phase detector |
| ret_i | input | 1 | Retard (slow-down) correction from the phase detector |
| thresh_i | input | THR_W | Run length needed to open the path; sampled at reset and re-arm |
| adv_o | output | 1 | Forwarded advance correction to the oscillator control |
| ret_o | output | 1 | Forwarded retard correction to the oscillator control |
| open_o | output | 1 | High while corrections are being passed through |
| rearm_o | output | 1 | One-cycle pulse when the filter re-arms |

## Verification
All four outputs are registered, so the effect of a correction presented in one cycle appears one cycle later. That holds for the forwarded pulse, the rise of `open_o`, and the `rearm_o` pulse with the matching fall of `open_o`. The re-arm itself is due exactly `GAP_WIN` idle cycles after the last correction, and its visible pulse follows one cycle after that. The bench drives inputs on the falling edge, advances a reference model by one step, and compares all outputs on the next falling edge. It also probes the outputs in the same cycle as the stimulus to confirm that nothing appears early. The directed cases place corrections at gaps of exactly `GAP_WIN` and `GAP_WIN`+1 cycles, and the checks are timed to those edges.

// File: rtl/cpbf_pkg.sv
package cpbf_pkg;

   typedef enum logic {
      MODE_CLOSED = 1'b0,
      MODE_OPEN   = 1'b1
   } mode_e;

   typedef enum logic {
      DIR_RET = 1'b0,
      DIR_ADV = 1'b1
   } dir_e;

   typedef struct packed {
      logic valid;
      dir_e dir;
   } corr_t;

endpackage

// File: rtl/cpbf_event_decode.sv
module cpbf_event_decode
   import cpbf_pkg::*;
(
   input  logic  adv_i,
   input  logic  ret_i,
   output corr_t corr_o
);

   // A correction exists only when exactly one request is raised.
   always_comb begin
      corr_o.valid = adv_i ^ ret_i;
      corr_o.dir   = adv_i ? DIR_ADV : DIR_RET;
   end

endmodule

// File: rtl/cpbf_run_tracker.sv
module cpbf_run_tracker
   import cpbf_pkg::*;
#(
   parameter int RUN_W   = 5,
   parameter int GAP_WIN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  corr_t            corr_i,
   output logic [RUN_W-1:0] cand_o,
   output logic             expire_o
);

   localparam int GAP_W = $clog2(GAP_WIN + 1);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_WIN - 1);
   localparam logic [RUN_W-1:0] RUN_MAX  = {RUN_W{1'b1}};
   localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

   logic [RUN_W-1:0] run_q;
   logic [GAP_W-1:0] gap_q;
   dir_e             dir_q;
   logic             active;
   logic             same_dir;

   assign active   = (run_q != '0);
   assign same_dir = active && (dir_q == corr_i.dir);

   always_comb begin
      if (!corr_i.valid)
         cand_o = run_q;
      else if (same_dir)
         cand_o = (run_q == RUN_MAX) ? RUN_MAX : run_q + RUN_ONE;
      else
         cand_o = RUN_ONE;
   end

   assign expire_o = !corr_i.valid && active && (gap_q == GAP_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         gap_q <= '0;
         dir_q <= DIR_RET;
      end else if (corr_i.valid) begin
         run_q <= cand_o;
         dir_q <= corr_i.dir;
         gap_q <= '0;
      end else if (expire_o) begin
         run_q <= '0;
         gap_q <= '0;
      end else if (active) begin
         gap_q <= gap_q + GAP_W'(1);
      end
   end

endmodule

// File: rtl/cpbf_gate.sv
module cpbf_gate
   import cpbf_pkg::*;
#(
   parameter int THR_W   = 4,
   parameter int RUN_W   = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  corr_t            corr_i,
   input  logic [RUN_W-1:0] cand_i,
   input  logic             expire_i,
   input  logic [THR_W-1:0] thresh_i,
   output logic             adv_o,
   output logic             ret_o,
   output logic             open_o,
   output logic             rearm_o,
   output logic [THR_W-1:0] thr_o
);

   mode_e            mode_q;
   logic [THR_W-1:0] thr_q;
   logic [RUN_W-1:0] thr_eff;
   logic             rearm_q;
   logic             reach;
   logic             pass_now;
   logic             fwd_adv;
   logic             fwd_ret;

   // A held threshold of zero behaves as one.
   assign thr_eff  = (thr_q == '0) ? RUN_W'(1) : RUN_W'(thr_q);
   assign reach    = corr_i.valid && (cand_i >= thr_eff);
   assign pass_now = (mode_q == MODE_OPEN) || reach;
   assign fwd_adv  = corr_i.valid && (corr_i.dir == DIR_ADV) && pass_now;
   assign fwd_ret  = corr_i.valid && (corr_i.dir == DIR_RET) && pass_now;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_CLOSED;
         thr_q   <= thresh_i;
         rearm_q <= 1'b0;
      end else begin
         rearm_q <= expire_i;
         if (expire_i) begin
            mode_q <= MODE_CLOSED;
            thr_q  <= thresh_i;
         end else if (reach) begin
            mode_q <= MODE_OPEN;
         end
      end
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic adv_q;
         logic ret_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               adv_q <= 1'b0;
               ret_q <= 1'b0;
            end else begin
               adv_q <= fwd_adv;
               ret_q <= fwd_ret;
            end
         end
         assign adv_o = adv_q;
         assign ret_o = ret_q;
      end else begin : g_comb_out
         assign adv_o = fwd_adv;
         assign ret_o = fwd_ret;
      end
   endgenerate

   assign open_o  = (mode_q == MODE_OPEN);
   assign rearm_o = rearm_q;
   assign thr_o   = thr_q;

endmodule

// File: rtl/cpbf_burst_filter.sv
module cpbf_burst_filter
   import cpbf_pkg::*;
#(
   parameter int THR_W   = 4,
   parameter int GAP_WIN = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             ret_i,
   input  logic [THR_W-1:0] thresh_i,
   output logic             adv_o,
   output logic             ret_o,
   output logic             open_o,
   output logic             rearm_o
);

   // One spare bit so a saturated run always exceeds any threshold.
   localparam int RUN_W = THR_W + 1;

   generate
      if (THR_W < 1 || THR_W > 16) begin : g_bad_thr
         $error("cpbf_burst_filter: THR_W must be 1..16");
      end
      if (GAP_WIN < 1) begin : g_bad_gap
         $error("cpbf_burst_filter: GAP_WIN must be at least 1");
      end
   endgenerate

   corr_t            corr;
   logic [RUN_W-1:0] cand;
   logic             expire;
   logic [THR_W-1:0] thr_q;

   cpbf_event_decode i_decode (
      .adv_i  (adv_i),
      .ret_i  (ret_i),
      .corr_o (corr)
   );

   cpbf_run_tracker #(
      .RUN_W   (RUN_W),
      .GAP_WIN (GAP_WIN)
   ) i_tracker (
      .clk      (clk),
      .rst_n    (rst_n),
      .corr_i   (corr),
      .cand_o   (cand),
      .expire_o (expire)
   );

   cpbf_gate #(
      .THR_W   (THR_W),
      .RUN_W   (RUN_W),
      .REG_OUT (REG_OUT)
   ) i_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .corr_i   (corr),
      .cand_i   (cand),
      .expire_i (expire),
      .thresh_i (thresh_i),
      .adv_o    (adv_o),
      .ret_o    (ret_o),
      .open_o   (open_o),
      .rearm_o  (rearm_o),
      .thr_o    (thr_q)
   );

endmodule

// File: rtl/cpbf_checker.sv
module cpbf_checker #(
   parameter int THR_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adv_i,
   input logic             ret_i,
   input logic             adv_o,
   input logic             ret_o,
   input logic             open_o,
   input logic             rearm_o,
   input logic [THR_W-1:0] thr_q
);

   // R2: never both directions forwarded at once
   p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv_o && ret_o));

   // R4: a forwarded correction means the path is open
   p_fwd_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_o || ret_o) |-> open_o);

   // R6: re-arm pulse lasts one cycle
   p_rearm_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_o |=> !rearm_o);

   // R6: the path closes only together with a re-arm
   p_close_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_o) |-> rearm_o);

   // R8: held threshold moves only at a re-arm
   p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(thr_q) |-> rearm_o);

   generate
      if (REG_OUT) begin : g_lat
         // R9: a forwarded pulse had a lone request one cycle earlier
         p_adv_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
            adv_o |-> $past(adv_i && !ret_i));
         p_ret_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ret_o |-> $past(ret_i && !adv_i));
      end
   endgenerate

endmodule

bind cpbf_burst_filter cpbf_checker #(
   .THR_W   (THR_W),
   .REG_OUT (REG_OUT)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .adv_i   (adv_i),
   .ret_i   (ret_i),
   .adv_o   (adv_o),
   .ret_o   (ret_o),
   .open_o  (open_o),
   .rearm_o (rearm_o),
   .thr_q   (thr_q)
);

// File: tb/test_cpbf_burst_filter.sv
module test_cpbf_burst_filter;

   localparam int THR_W   = 4;
   localparam int GAP_WIN = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             adv_i = 1'b0;
   logic             ret_i = 1'b0;
   logic [THR_W-1:0] thresh_i = '0;
   logic             adv_o, ret_o, open_o, rearm_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   int m_run, m_gap, m_thr;
   bit m_dir, m_open;
   bit e_adv, e_ret, e_open, e_rearm;

   always #2.5 clk = ~clk;

   cpbf_burst_filter #(.THR_W(THR_W), .GAP_WIN(GAP_WIN)) i_cpbf_burst_filter (
      .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .ret_i(ret_i),
      .thresh_i(thresh_i), .adv_o(adv_o), .ret_o(ret_o),
      .open_o(open_o), .rearm_o(rearm_o));

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // one step of the model, written from the requirements
   function automatic void model_step(bit a, bit r, int thr_in);
      bit ev, expire, reach;
      int cand, thr_eff;
      ev = a ^ r;
      if (!ev) cand = m_run;
      else if (m_run != 0 && m_dir == a) cand = (m_run == 31) ? 31 : m_run + 1;
      else cand = 1;
      thr_eff = (m_thr == 0) ? 1 : m_thr;
      reach   = ev && cand >= thr_eff;
      expire  = !ev && m_run != 0 && m_gap == GAP_WIN - 1;
      e_adv   = ev && a && (m_open || reach);
      e_ret   = ev && r && (m_open || reach);
      e_rearm = expire;
      if (ev) begin m_run = cand; m_dir = a; m_gap = 0; end
      else if (expire) begin m_run = 0; m_gap = 0; end
      else if (m_run != 0) m_gap++;
      if (expire) begin m_open = 1'b0; m_thr = thr_in; end
      else if (reach) m_open = 1'b1;
      e_open = m_open;
   endfunction

   // called on a falling edge; returns on the next falling edge after compare
   task automatic cyc(bit a, bit r);
      adv_i = a; ret_i = r;
      model_step(a, r, int'(thresh_i));
      @(negedge clk);
      chk("R3 adv_o", adv_o, e_adv);
      chk("R3 ret_o", ret_o, e_ret);
      chk("R4 open_o", open_o, e_open);
      chk("R6 rearm_o", rearm_o, e_rearm);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0);
   endtask

   task automatic do_reset(int thr);
      thresh_i = THR_W'(thr);
      rst_n = 1'b0; adv_i = 0; ret_i = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_run = 0; m_gap = 0; m_dir = 0; m_open = 0; m_thr = thr;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset(3);
      // R1 reset state
      chk("R1 adv_o", adv_o, 1'b0);
      chk("R1 ret_o", ret_o, 1'b0);
      chk("R1 open_o", open_o, 1'b0);
      chk("R1 rearm_o", rearm_o, 1'b0);

      // R3/R4: two advances withheld, third opens the path
      cyc(1, 0); chk("R3 first withheld", adv_o, 1'b0);
      idle(2);
      cyc(1, 0); chk("R3 second withheld", adv_o, 1'b0);
      adv_i = 1; ret_i = 0;
      #1 chk("R9 no same-cycle output", adv_o, 1'b0);
      cyc(1, 0); chk("R4 third forwarded", adv_o, 1'b1);
      chk("R4 open", open_o, 1'b1);
      // R7 open path passes either direction
      cyc(0, 1); chk("R7 retard passes when open", ret_o, 1'b1);
      // R6 re-arm after GAP_WIN idle cycles
      idle(GAP_WIN);
      chk("R6 rearm pulse", rearm_o, 1'b1);
      chk("R6 closed", open_o, 1'b0);
      idle(1); chk("R6 one cycle", rearm_o, 1'b0);

      // R5 gap of GAP_WIN+1 breaks the run
      for (int k = 0; k < 4; k++) begin
         cyc(0, 1); chk("R5 long gap withheld", ret_o, 1'b0);
         idle(GAP_WIN);
      end
      // R5 gap of exactly GAP_WIN keeps the run
      cyc(0, 1); idle(GAP_WIN - 1);
      cyc(0, 1); idle(GAP_WIN - 1);
      cyc(0, 1); chk("R5 exact gap opens", ret_o, 1'b1);
      idle(GAP_WIN + 2);

      // R7 direction flip restarts while closed
      cyc(1, 0); cyc(1, 0); cyc(0, 1); cyc(0, 1);
      chk("R7 flip withheld", ret_o, 1'b0);
      chk("R7 still closed", open_o, 1'b0);
      idle(GAP_WIN + 2);

      // R2 both raised is ignored and does not extend the run
      cyc(1, 0); cyc(1, 1); chk("R2 both ignored", adv_o, 1'b0);
      cyc(1, 0); chk("R2 run not extended", adv_o, 1'b0);
      cyc(1, 0); chk("R2 run resumes", adv_o, 1'b1);
      idle(GAP_WIN + 2);

      // R8 threshold change mid-operation has no effect until re-arm
      do_reset(5);
      thresh_i = 4'd1;
      cyc(1, 0); chk("R8 old threshold holds", adv_o, 1'b0);
      idle(GAP_WIN);
      chk("R8 rearm", rearm_o, 1'b1);
      idle(1);
      cyc(1, 0); chk("R8 new threshold used", adv_o, 1'b1);
      idle(GAP_WIN + 2);

      // R3 threshold 0 acts as 1
      thresh_i = 4'd0; do_reset(0);
      cyc(0, 1); chk("R3 zero threshold", ret_o, 1'b1);
      idle(GAP_WIN + 2);

      // constrained random
      do_reset(4);
      for (int n = 0; n < 6000; n++) begin
         int r;
         bit d;
         r = int'($urandom % 100);
         if (r < 2) thresh_i = THR_W'($urandom);
         d = ($urandom % 8) != 0 ? m_dir : ~m_dir;
         r = int'($urandom % 100);
         if (r < 40) cyc(d, ~d);
         else if (r < 43) cyc(1, 1);
         else if (r < 46) idle(int'($urandom % 14));
         else cyc(0, 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule